// File: doc/BRIEF.md
# Nested Trap Entry Sequencer

This block carries out the entry half of taking a trap on a 64-bit processor with register windows and nested trap levels. The pipeline presents the trap type together with the architectural state at the point of the trap: the program counter and next program counter, condition codes, address-space identifier, processor-state word, current window pointer, CANSAVE count, trap base address and current trap level. It then strobes a one-cycle request.

On the next clock the block produces the state the processor resumes with. It raises the trap level, enters the recovery (RED) state when the trap takes the last free level, picks one of three global register sets according to the trap class, and moves the window pointer for clean-window, spill and fill traps. It also computes the vector address and stores a snapshot of the interrupted state in a per-level save stack. The save stack can be read at any level through a combinational read port. A trap that arrives with no trap level left is reported as an error and leaves every result untouched.

Top module: `trap_entry_seq`

## Requirements
- R1: When a request arrives with the trap level at or above MAX_TL (default 6), `err_o` pulses together with `done_o`. The level, processor-state, window, PC and next-PC outputs keep their previous values, and no save-stack slot is written.
- R2: Otherwise the new trap level is the input level plus one. When the input level equals MAX_TL-1, the recovery bit (processor-state bit 5) is also set, in both the new processor state and the saved one.
- R3: The saved state word is 40 bits wide. Bits 39:32 hold the condition codes and bits 31:24 hold the ASI. Bits 19:8 hold the processor state (with the recovery bit applied) ANDed with 0xF3F. Bits 7:0 hold the window pointer, zero-extended. All other bits are zero.
- R4: The save-stack slot indexed by the new trap level modulo STK_DEPTH (default 8) records the saved state word, the trapping PC, the next PC and the 9-bit trap type. That slot can be read through `rd_lvl_i`. All slots read as zero after reset.
- R5: The global set is chosen by trap type. Type 0x060 selects the interrupt globals (processor-state bit 11). Types 0x008, 0x030 and 0x064 through 0x06F select the MMU globals (bit 10). Every other type selects the alternate globals (bit 0). The other two of these three bits are cleared, privileged (bit 2) and FPU-enable (bit 4) are set, and all remaining bits pass through unchanged.
- R6: Trap type 0x024 (clean window) decrements the window pointer by one, wrapping modulo NWIN (default 8).
- R7: A trap whose type has bits 8:6 equal to 3'b010 (spill, 0x080 to 0x0BF) sets the window pointer to current minus CANSAVE minus 2. Bits 8:6 equal to 3'b011 (fill, 0x0C0 to 0x0FF) set it to current plus 1. Both wrap modulo NWIN. Any other type, including 0x100 to 0x17F, leaves the pointer unchanged.
- R8: The new PC is the trap base address with bits 14:0 cleared. Bit 14 is set when the new trap level exceeds 1, and the trap type occupies bits 13:5. The new next PC is the new PC plus 4.
- R9: `done_o` is high for exactly the one cycle after the request cycle. All result outputs change on that same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle trap request |
| tt_i | input | 9 | Trap type |
| pc_i | input | 64 | PC of the trapping instruction |
| npc_i | input | 64 | Next PC at the trap |
| ccr_i | input | 8 | Condition codes |
| asi_i | input | 8 | Address-space identifier |
| pstate_i | input | 12 | Processor-state word |
| cwp_i | input | 3 | Current window pointer |
| cansave_i | input | 3 | CANSAVE count |
| tba_i | input | 64 | Trap base address |
| tl_i | input | 3 | Current trap level |
| done_o | output | 1 | Trap entry finished |
| err_o | output | 1 | Trap taken with no level left |
| tl_o | output | 3 | New trap level |
| pstate_o | output | 12 | New processor state |
| cwp_o | output | 3 | New window pointer |
| pc_o | output | 64 | Vector PC |
| npc_o | output | 64 | Vector next PC |
| rd_lvl_i | input | 3 | Save-stack read index |
| rd_tstate_o | output | 40 | Saved state word at the read index |
| rd_tpc_o | output | 64 | Saved PC at the read index |
| rd_tnpc_o | output | 64 | Saved next PC at the read index |
| rd_tt_o | output | 9 | Saved trap type at the read index |

## Verification
The assertions assume that requests are never issued on back-to-back cycles, that CANSAVE stays below the window count, and that trap inputs are stable during the request cycle. The bench raises `req_i` for a single cycle and then leaves at least two idle cycles before the next request. It draws CANSAVE only from 0 to 7 and changes inputs only on the falling edge. Trap levels cover 0 through 7, so both the recovery transition and both fatal levels are reached under these same rules.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  localparam int VA_W     = 64;
  localparam int TT_W     = 9;
  localparam int PST_W    = 12;
  localparam int TSTATE_W = 40;

  // processor-state bit positions
  localparam int PS_AG   = 0;
  localparam int PS_PRIV = 2;
  localparam int PS_PEF  = 4;
  localparam int PS_RED  = 5;
  localparam int PS_MG   = 10;
  localparam int PS_IG   = 11;

  localparam logic [PST_W-1:0] SAVE_PST_MASK = 12'hF3F;

  // trap type codes this block decodes
  localparam logic [TT_W-1:0] TT_INTR_VEC  = 9'h060;
  localparam logic [TT_W-1:0] TT_INSN_FLT  = 9'h008;
  localparam logic [TT_W-1:0] TT_DATA_FLT  = 9'h030;
  localparam logic [TT_W-1:0] TT_MMU_FIRST = 9'h064;
  localparam logic [TT_W-1:0] TT_MMU_LAST  = 9'h06F;
  localparam logic [TT_W-1:0] TT_CLEAN_WIN = 9'h024;
  localparam logic [2:0]      GRP_SPILL    = 3'b010;
  localparam logic [2:0]      GRP_FILL     = 3'b011;

  typedef enum logic [1:0] {
    GSET_ALT  = 2'd0,
    GSET_MMU  = 2'd1,
    GSET_INTR = 2'd2
  } gset_e;

  typedef struct packed {
    logic [TSTATE_W-1:0] tstate;
    logic [VA_W-1:0]     tpc;
    logic [VA_W-1:0]     tnpc;
    logic [TT_W-1:0]     tt;
  } save_ent_t;

  function automatic gset_e gset_of(input logic [TT_W-1:0] tt);
    if (tt == TT_INTR_VEC)
      return GSET_INTR;
    else if (tt == TT_INSN_FLT || tt == TT_DATA_FLT ||
             (tt >= TT_MMU_FIRST && tt <= TT_MMU_LAST))
      return GSET_MMU;
    else
      return GSET_ALT;
  endfunction

endpackage

// File: rtl/trap_level_ctl.sv
module trap_level_ctl #(
  parameter int MAX_TL = 6,
  parameter int TL_W   = 3
) (
  input  logic [TL_W-1:0] tl_i,
  output logic            fatal_o,
  output logic            red_o,
  output logic [TL_W-1:0] tl_next_o,
  output logic            tl_above1_o
);

  localparam logic [TL_W-1:0] LIMIT   = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] LAST_OK = TL_W'(MAX_TL - 1);

  always_comb begin
    fatal_o     = (tl_i >= LIMIT);
    red_o       = (tl_i >= LAST_OK);
    tl_next_o   = tl_i + TL_W'(1);
    tl_above1_o = (tl_next_o > TL_W'(1));
  end

endmodule

// File: rtl/trap_pstate_ctl.sv
module trap_pstate_ctl
  import trap_seq_pkg::*;
(
  input  logic [TT_W-1:0]  tt_i,
  input  logic [PST_W-1:0] pstate_i,
  input  logic             red_i,
  output logic [PST_W-1:0] pst_saved_o,
  output logic [PST_W-1:0] pst_next_o
);

  gset_e gset;

  always_comb begin
    gset        = gset_of(tt_i);
    pst_saved_o = pstate_i;
    if (red_i)
      pst_saved_o[PS_RED] = 1'b1;

    pst_next_o          = pst_saved_o;
    pst_next_o[PS_AG]   = 1'b0;
    pst_next_o[PS_MG]   = 1'b0;
    pst_next_o[PS_IG]   = 1'b0;
    pst_next_o[PS_PRIV] = 1'b1;
    pst_next_o[PS_PEF]  = 1'b1;
    case (gset)
      GSET_INTR: pst_next_o[PS_IG] = 1'b1;
      GSET_MMU:  pst_next_o[PS_MG] = 1'b1;
      default:   pst_next_o[PS_AG] = 1'b1;
    endcase
  end

endmodule

// File: rtl/trap_cwp_ctl.sv
module trap_cwp_ctl
  import trap_seq_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CWP_W = 3
) (
  input  logic [TT_W-1:0]  tt_i,
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [CWP_W-1:0] cansave_i,
  output logic [CWP_W-1:0] cwp_next_o
);

  localparam bit POW2 = ((NWIN & (NWIN - 1)) == 0);

  logic [CWP_W-1:0] dec1, spill_w, fill_w;

  generate
    if (POW2) begin : g_wrap_pow2
      always_comb begin
        dec1    = cwp_i - CWP_W'(1);
        spill_w = cwp_i - cansave_i - CWP_W'(2);
        fill_w  = cwp_i + CWP_W'(1);
      end
    end else begin : g_wrap_mod
      always_comb begin
        dec1    = CWP_W'((int'(cwp_i) + NWIN - 1) % NWIN);
        spill_w = CWP_W'((int'(cwp_i) + 2 * NWIN - int'(cansave_i) - 2) % NWIN);
        fill_w  = CWP_W'((int'(cwp_i) + 1) % NWIN);
      end
    end
  endgenerate

  always_comb begin
    cwp_next_o = cwp_i;
    if (tt_i == TT_CLEAN_WIN)
      cwp_next_o = dec1;
    else if (tt_i[8:6] == GRP_SPILL)
      cwp_next_o = spill_w;
    else if (tt_i[8:6] == GRP_FILL)
      cwp_next_o = fill_w;
  end

endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trap_seq_pkg::*;
(
  input  logic [VA_W-1:0] tba_i,
  input  logic [TT_W-1:0] tt_i,
  input  logic            nested_i,
  output logic [VA_W-1:0] pc_o,
  output logic [VA_W-1:0] npc_o
);

  localparam logic [VA_W-1:0] BASE_MASK = ~VA_W'(64'h7FFF);

  logic [VA_W-1:0] offset;

  always_comb begin
    offset = VA_W'({nested_i, tt_i, 5'b0_0000});
    pc_o   = (tba_i & BASE_MASK) | offset;
    npc_o  = pc_o + VA_W'(4);
  end

endmodule

// File: rtl/trap_save_stack.sv
module trap_save_stack
  import trap_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wa_i,
  input  save_ent_t        wd_i,
  input  logic [IDX_W-1:0] ra_i,
  output save_ent_t        rd_o
);

  save_ent_t slot_view [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      save_ent_t ent_q;
      logic      ent_en;

      assign ent_en = we_i && (wa_i == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ent_q <= '0;
        else if (ent_en)
          ent_q <= wd_i;
      end

      assign slot_view[g] = ent_q;
    end
  endgenerate

  assign rd_o = slot_view[ra_i];

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int NWIN      = 8,
  parameter int MAX_TL    = 6,
  parameter int STK_DEPTH = 8,
  localparam int CWP_W    = $clog2(NWIN),
  localparam int TL_W     = $clog2(STK_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic [TT_W-1:0]     tt_i,
  input  logic [VA_W-1:0]     pc_i,
  input  logic [VA_W-1:0]     npc_i,
  input  logic [7:0]          ccr_i,
  input  logic [7:0]          asi_i,
  input  logic [PST_W-1:0]    pstate_i,
  input  logic [CWP_W-1:0]    cwp_i,
  input  logic [CWP_W-1:0]    cansave_i,
  input  logic [VA_W-1:0]     tba_i,
  input  logic [TL_W-1:0]     tl_i,
  output logic                done_o,
  output logic                err_o,
  output logic [TL_W-1:0]     tl_o,
  output logic [PST_W-1:0]    pstate_o,
  output logic [CWP_W-1:0]    cwp_o,
  output logic [VA_W-1:0]     pc_o,
  output logic [VA_W-1:0]     npc_o,
  input  logic [TL_W-1:0]     rd_lvl_i,
  output logic [TSTATE_W-1:0] rd_tstate_o,
  output logic [VA_W-1:0]     rd_tpc_o,
  output logic [VA_W-1:0]     rd_tnpc_o,
  output logic [TT_W-1:0]     rd_tt_o
);

  // ---------------- combinational trap datapath ----------------
  logic             fatal, red, above1;
  logic [TL_W-1:0]  tl_nx;
  logic [PST_W-1:0] pst_saved, pst_nx;
  logic [CWP_W-1:0] cwp_nx;
  logic [VA_W-1:0]  vec_pc, vec_npc;
  logic             commit;
  save_ent_t        wr_ent, rd_ent;

  trap_level_ctl #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_level (
    .tl_i        (tl_i),
    .fatal_o     (fatal),
    .red_o       (red),
    .tl_next_o   (tl_nx),
    .tl_above1_o (above1)
  );

  trap_pstate_ctl u_pstate (
    .tt_i        (tt_i),
    .pstate_i    (pstate_i),
    .red_i       (red),
    .pst_saved_o (pst_saved),
    .pst_next_o  (pst_nx)
  );

  trap_cwp_ctl #(.NWIN(NWIN), .CWP_W(CWP_W)) u_cwp (
    .tt_i       (tt_i),
    .cwp_i      (cwp_i),
    .cansave_i  (cansave_i),
    .cwp_next_o (cwp_nx)
  );

  trap_vector_gen u_vec (
    .tba_i    (tba_i),
    .tt_i     (tt_i),
    .nested_i (above1),
    .pc_o     (vec_pc),
    .npc_o    (vec_npc)
  );

  assign commit = req_i && !fatal;

  always_comb begin
    wr_ent.tstate = {ccr_i, asi_i, 4'b0000, pst_saved & SAVE_PST_MASK,
                     {(8 - CWP_W){1'b0}}, cwp_i};
    wr_ent.tpc    = pc_i;
    wr_ent.tnpc   = npc_i;
    wr_ent.tt     = tt_i;
  end

  trap_save_stack #(.DEPTH(STK_DEPTH), .IDX_W(TL_W)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (commit),
    .wa_i  (tl_nx),
    .wd_i  (wr_ent),
    .ra_i  (rd_lvl_i),
    .rd_o  (rd_ent)
  );

  assign rd_tstate_o = rd_ent.tstate;
  assign rd_tpc_o    = rd_ent.tpc;
  assign rd_tnpc_o   = rd_ent.tnpc;
  assign rd_tt_o     = rd_ent.tt;

  // ---------------- result registers: next state ----------------
  logic             done_d, err_d;
  logic [TL_W-1:0]  tl_d;
  logic [PST_W-1:0] pst_d;
  logic [CWP_W-1:0] cwp_d;
  logic [VA_W-1:0]  pc_d, npc_d;
  logic             res_en;

  always_comb begin
    done_d = req_i;
    err_d  = req_i && fatal;
    res_en = commit;
    tl_d   = tl_nx;
    pst_d  = pst_nx;
    cwp_d  = cwp_nx;
    pc_d   = vec_pc;
    npc_d  = vec_npc;
  end

  // ---------------- result registers: state ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= done_d;
      err_o  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tl_o     <= '0;
      pstate_o <= '0;
      cwp_o    <= '0;
      pc_o     <= '0;
      npc_o    <= '0;
    end else if (res_en) begin
      tl_o     <= tl_d;
      pstate_o <= pst_d;
      cwp_o    <= cwp_d;
      pc_o     <= pc_d;
      npc_o    <= npc_d;
    end
  end

  // ---------------- assertions ----------------
  AST_ERR_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (err_o == ($past(tl_i) >= TL_W'(MAX_TL))));  // R1

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($stable(tl_o) && $stable(pstate_o) && $stable(cwp_o) &&
               $stable(pc_o) && $stable(npc_o)));  // R1

  AST_TL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (tl_o == $past(tl_i) + TL_W'(1)));  // R2

  AST_RED_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o && tl_o == TL_W'(MAX_TL)) |-> pstate_o[PS_RED]);  // R2

  AST_ONE_GSET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> ($countones({pstate_o[PS_IG], pstate_o[PS_MG], pstate_o[PS_AG]}) == 1
                            && pstate_o[PS_PRIV] && pstate_o[PS_PEF]));  // R5

  AST_CWP_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o && $past(tt_i) != TT_CLEAN_WIN && $past(tt_i[8:7]) != 2'b01)
      |-> (cwp_o == $past(cwp_i)));  // R7

  AST_VEC_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (pc_o[13:5] == $past(tt_i) && pc_o[4:0] == 5'd0 &&
                            pc_o[14] == (tl_o > TL_W'(1))));  // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !$past(req_i)) |=> (done_o ##1 !done_o));  // R9

endmodule

// File: tb/trap_entry_seq_tb.sv
`timescale 1ns/100ps
module trap_entry_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [8:0]  tt;
  logic [63:0] pc, npc, tba;
  logic [7:0]  ccr, asi;
  logic [11:0] pst;
  logic [2:0]  cwp, cansave, tl, rd_lvl;
  logic        done, err;
  logic [2:0]  tl_o, cwp_o;
  logic [11:0] pst_o;
  logic [63:0] pc_o, npc_o, rd_tpc, rd_tnpc;
  logic [39:0] rd_ts;
  logic [8:0]  rd_tt;

  int checks = 0;
  int errors = 0;
  int seq    = 0;

  // reference model state
  logic [2:0]  e_tl = '0, e_cwp = '0;
  logic [11:0] e_pst = '0;
  logic [63:0] e_pc = '0, e_npc = '0;
  logic [39:0] m_ts  [8];
  logic [63:0] m_pc  [8];
  logic [63:0] m_npc [8];
  logic [8:0]  m_tt  [8];

  always #2.5 clk = ~clk;

  trap_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .tt_i(tt), .pc_i(pc), .npc_i(npc),
    .ccr_i(ccr), .asi_i(asi), .pstate_i(pst), .cwp_i(cwp), .cansave_i(cansave),
    .tba_i(tba), .tl_i(tl), .done_o(done), .err_o(err), .tl_o(tl_o),
    .pstate_o(pst_o), .cwp_o(cwp_o), .pc_o(pc_o), .npc_o(npc_o),
    .rd_lvl_i(rd_lvl), .rd_tstate_o(rd_ts), .rd_tpc_o(rd_tpc),
    .rd_tnpc_o(rd_tnpc), .rd_tt_o(rd_tt)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_slot(input int s, input string tag);
    rd_lvl = 3'(s);
    #1;
    chk(rd_ts   == m_ts[s],  {tag, " tstate"}, 64'(rd_ts),   64'(m_ts[s]));
    chk(rd_tpc  == m_pc[s],  {tag, " tpc"},    rd_tpc,       m_pc[s]);
    chk(rd_tnpc == m_npc[s], {tag, " tnpc"},   rd_tnpc,      m_npc[s]);
    chk(rd_tt   == m_tt[s],  {tag, " tt"},     64'(rd_tt),   64'(m_tt[s]));
  endtask

  // one trap: drive at a falling edge, compare on each following falling edge
  task automatic fire(input logic [8:0] t, input logic [2:0] lvl,
                      input logic [2:0] w, input logic [2:0] cs,
                      input logic [11:0] p, input logic [63:0] base);
    bit          fatal;
    int          slot;
    logic [11:0] ps;
    logic [63:0] vpc;
    seq++;
    tt = t; tl = lvl; cwp = w; cansave = cs; pst = p; tba = base;
    pc  = 64'h0000_4000_0000_0000 + 64'(seq) * 64'h40;
    npc = pc + 64'd4;
    ccr = 8'(8'h5A ^ seq);
    asi = 8'(8'h80 + seq);
    fatal = (int'(lvl) >= 6);
    if (!fatal) begin
      e_tl = lvl + 3'd1;
      ps = p;
      if (int'(lvl) == 5) ps = ps | 12'h020;
      slot = int'(e_tl);
      m_ts[slot]  = (40'(ccr) << 32) | (40'(asi) << 24) | (40'(ps & 12'hF3F) << 8) | 40'(w);
      m_pc[slot]  = pc;
      m_npc[slot] = npc;
      m_tt[slot]  = t;
      ps = ps & ~12'hC01;
      ps = ps | 12'h014;
      if (t == 9'h060) ps = ps | 12'h800;
      else if (t == 9'h008 || t == 9'h030 || (t >= 9'h064 && t <= 9'h06F)) ps = ps | 12'h400;
      else ps = ps | 12'h001;
      e_pst = ps;
      if (t == 9'h024)        e_cwp = 3'((int'(w) + 7) % 8);
      else if (t[8:6] == 3'b010) e_cwp = 3'((int'(w) - int'(cs) - 2 + 16) % 8);
      else if (t[8:6] == 3'b011) e_cwp = 3'((int'(w) + 1) % 8);
      else                    e_cwp = w;
      vpc = (base & ~64'h7FFF) | ((e_tl > 3'd1) ? 64'h4000 : 64'h0) | (64'(t) << 5);
      e_pc = vpc;
      e_npc = vpc + 64'd4;
    end else begin
      slot = (int'(lvl) + 1) % 8;
    end
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(done == 1'b1, "R9 done after request", 64'(done), 64'd1);
    chk(err == fatal, "R1 error flag", 64'(err), 64'(fatal));
    chk(tl_o == e_tl, fatal ? "R1 level held" : "R2 level", 64'(tl_o), 64'(e_tl));
    chk(pst_o == e_pst, fatal ? "R1 pstate held" : "R5 pstate", 64'(pst_o), 64'(e_pst));
    chk(cwp_o == e_cwp, fatal ? "R1 cwp held" : "R6 R7 cwp", 64'(cwp_o), 64'(e_cwp));
    chk(pc_o == e_pc, fatal ? "R1 pc held" : "R8 pc", pc_o, e_pc);
    chk(npc_o == e_npc, fatal ? "R1 npc held" : "R8 npc", npc_o, e_npc);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", 64'(done), 64'd0);
    chk_slot(slot, fatal ? "R1 slot untouched" : "R3 R4 slot");
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_ts[i] = '0; m_pc[i] = '0; m_npc[i] = '0; m_tt[i] = '0;
    end
    rst_n = 1'b0; req = 1'b0; tt = '0; pc = '0; npc = '0; tba = '0;
    ccr = '0; asi = '0; pst = '0; cwp = '0; cansave = '0; tl = '0; rd_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && err == 1'b0, "R9 reset flags", 64'({done, err}), 64'd0);
    chk(tl_o == 3'd0 && pc_o == 64'd0, "R2 reset results", pc_o, 64'd0);
    chk_slot(3, "R4 reset slot");

    // global-set classes and pstate masking
    fire(9'h010, 3'd0, 3'd2, 3'd1, 12'h0C2, 64'hFFFF_0000_0001_ABCD); // R5 alt, R8 tl=1
    fire(9'h060, 3'd1, 3'd3, 3'd0, 12'hC01, 64'h0000_0000_1234_8000); // R5 intr
    fire(9'h008, 3'd2, 3'd4, 3'd2, 12'h801, 64'h0000_0000_0001_0000); // R5 mmu
    fire(9'h030, 3'd0, 3'd5, 3'd2, 12'h002, 64'h0000_0000_0001_0000); // R5 mmu
    fire(9'h064, 3'd1, 3'd1, 3'd2, 12'h300, 64'h0000_0000_0002_0000); // R5 mmu low edge
    fire(9'h06B, 3'd1, 3'd1, 3'd2, 12'h000, 64'h0000_0000_0002_0000); // R5 mmu
    fire(9'h06F, 3'd2, 3'd1, 3'd2, 12'h400, 64'h0000_0000_0002_0000); // R5 mmu high edge
    fire(9'h070, 3'd2, 3'd1, 3'd2, 12'h400, 64'h0000_0000_0002_0000); // R5 past range -> alt
    fire(9'h063, 3'd3, 3'd1, 3'd2, 12'h000, 64'h0000_0000_0002_0000); // R5 below range -> alt
    // window pointer
    fire(9'h024, 3'd0, 3'd0, 3'd3, 12'h000, 64'h0000_0000_0004_0000); // R6 wrap 0 -> 7
    fire(9'h024, 3'd2, 3'd5, 3'd3, 12'h000, 64'h0000_0000_0004_0000); // R6
    fire(9'h080, 3'd1, 3'd1, 3'd6, 12'h000, 64'h0000_0000_0004_0000); // R7 spill wrap
    fire(9'h0BF, 3'd3, 3'd3, 3'd0, 12'h000, 64'h0000_0000_0004_0000); // R7 spill
    fire(9'h0C0, 3'd2, 3'd7, 3'd4, 12'h000, 64'h0000_0000_0004_0000); // R7 fill wrap
    fire(9'h0FF, 3'd0, 3'd2, 3'd4, 12'h000, 64'h0000_0000_0004_0000); // R7 fill
    fire(9'h100, 3'd1, 3'd6, 3'd5, 12'h000, 64'h0000_0000_0004_0000); // R7 trap insn unchanged
    fire(9'h17F, 3'd4, 3'd6, 3'd5, 12'h010, 64'hABCD_0000_0008_7FFF); // R7 R8
    // recovery state and fatal levels
    fire(9'h041, 3'd5, 3'd3, 3'd1, 12'h016, 64'h0000_0000_0010_0000); // R2 red, tl=6
    fire(9'h041, 3'd6, 3'd4, 3'd1, 12'h000, 64'h0000_0000_0020_0000); // R1 at limit
    fire(9'h060, 3'd7, 3'd4, 3'd1, 12'h000, 64'h0000_0000_0020_0000); // R1 above limit
    fire(9'h041, 3'd4, 3'd0, 3'd0, 12'h000, 64'h0000_0000_0030_0000); // R2 no red at tl=4

    for (int s = 0; s < 8; s++) chk_slot(s, "R4 final stack");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule